// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single asynchronous characters to and from a smart card over one shared, open-drain I/O line. Each character is a low start bit, eight data bits and an even parity bit, and every bit lasts one elementary time unit (etu). The etu is a programmable number of clock cycles. The host writes a byte with a strobe and receives bytes as a one-cycle result pulse that carries the data and a parity-error flag. The line is half-duplex: the receiver is held idle while a character is being sent.

Four mode settings shape the link. Bit order chooses whether data leaves and arrives least or most significant bit first. Inversion complements the data bits, so the block can talk to inverse-convention cards. Protocol select picks character-level error recovery (T=0) or none (T=1). A last-character switch shortens the guard time to exactly two etu. Bit order and inversion act only on the data bits. The parity bit is always even parity over the data bits as they appear on the line.

The modes, the etu length and the extra guard count sit in a configuration register that loads on a strobe. The host sets them before a transfer.

Top module: `sc_xcvr`

## Requirements
- R1: After reset the line is released (io_oe low), tx_busy, rx_valid and rx_perr are low, all mode fields are 0, the extra guard count is 0 and the etu is 372 cycles. A character written right after reset keeps tx_busy high for 12 × 372 cycles.
- R2: A write accepted while idle drives the start bit low from the cycle after tx_wr. Then come 8 data bits and the parity bit, each held for exactly one etu. The parity bit makes the count of ones over the 8 line data bits plus parity even.
- R3: With bit order 0, data bit 0 is the first data bit on the line, and the first received data bit is stored in rx_data bit 0. With bit order 1, data bit 7 goes first, and the first received bit is stored in rx_data bit 7.
- R4: With inversion 1, each transmitted data bit is the complement of the written bit, and each received data bit is complemented before it is stored. The parity bit is never inverted; it is computed over the data bits as they appear on the line.
- R5: After the parity bit the transmitter keeps tx_busy high for a guard of 2 + guard-extension etu. With the last-character mode set, the guard is exactly 2 etu whatever the guard extension holds.
- R6: A tx_wr that arrives while tx_busy is high is ignored. The character in flight and the busy time do not change.
- R7: A low pulse on the line that is no longer low at the middle of the start bit is rejected as a false start and produces no receive result.
- R8: In T=0, a received character with a parity error gives a one-cycle rx_perr pulse with rx_valid low. The receiver also drives the line low for one etu, starting half an etu after the end of the parity bit.
- R9: In T=1, a received parity error never drives the line. rx_valid pulses together with rx_perr and carries the data.
- R10: In T=0, a transmitter that sees the line low one etu after the end of its parity bit sends the same character again once the guard ends. In T=1 it never sends a character again.
- R11: Mode, etu and guard inputs take effect only on a cycle with cfg_load high. Changes to them at other times have no effect.
- R12: While tx_busy is high the receiver produces no results and does not drive the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Loads the configuration inputs into the mode register |
| cfg_msb_first | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| cfg_invert | input | 1 | Data inversion: 1 complements data bits |
| cfg_t1 | input | 1 | Protocol: 0 T=0, 1 T=1 |
| cfg_last_char | input | 1 | 1 forces a 2 etu guard |
| cfg_etu | input | ETU_W | Etu length in clock cycles (at least 4) |
| cfg_guard | input | GUARD_W | Extra guard etu beyond 2 |
| tx_wr | input | 1 | Transmit write strobe |
| tx_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Character or guard in progress |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: rx_data accepted |
| rx_perr | output | 1 | One-cycle pulse: parity error seen |
| io_in | input | 1 | Level of the shared I/O line |
| io_oe | output | 1 | 1 pulls the I/O line low |

## Verification
A stuck or skipped bit index in the transmitter shows up within one character. The bit captured at some etu midpoint is wrong, or the busy time differs from (10 + guard) etu. A receiver that loses its etu phase or shift order puts out a wrong byte or parity flag on the very next result pulse. The error window on the line opens or closes at the wrong place within two etu of the parity bit. A bad guard or retry decision shows as a busy time that is off by whole etu or whole frames. Mode state that loads when it should not changes the busy time of the next character.

// File: rtl/sc_pkg.sv
package sc_pkg;

   typedef struct packed {
      logic msb_first;
      logic invert;
      logic t1;
      logic last_char;
   } sc_mode_t;

   // line order <-> byte order, then optional complement (an involution)
   function automatic logic [7:0] sc_map_byte(input logic [7:0] b,
                                              input logic       msb,
                                              input logic       inv);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = msb ? b[7-i] : b[i];
      return r ^ {8{inv}};
   endfunction

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("sc_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) s_q <= RST_VAL;
         else        s_q <= d;
      assign q = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) s_q <= {STAGES{RST_VAL}};
         else        s_q <= {s_q[STAGES-2:0], d};
      assign q = s_q[STAGES-1];
   end
endmodule

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
   parameter int W    = 16,
   parameter bit HALF = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] len,
   output logic         tick
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt;
   logic         wrap;

   assign wrap = (cnt == len - ONE);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (wrap)    cnt <= '0;
      else              cnt <= cnt + ONE;

   if (HALF) begin : g_mid
      assign tick = (cnt == (len >> 1) - ONE);
   end else begin : g_end
      assign tick = wrap;
   end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
   import sc_pkg::*;
#(
   parameter int ETU_W   = 16,
   parameter int GUARD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  sc_mode_t           mode,
   input  logic [ETU_W-1:0]   etu_len,
   input  logic [GUARD_W-1:0] guard_ext,
   input  logic               wr,
   input  logic [7:0]         wdata,
   input  logic               line_s,
   output logic               busy,
   output logic               oe
);
   localparam int GL_W = GUARD_W + 1;
   localparam logic [GL_W-1:0] G_ONE = GL_W'(1);
   localparam logic [GL_W-1:0] G_TWO = GL_W'(2);

   typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_GUARD} tx_st_e;

   tx_st_e          st;
   logic [3:0]      bit_idx;
   logic [GL_W-1:0] g_idx;
   logic [GL_W-1:0] guard_len;
   logic [9:0]      frame;
   logic            err_seen;
   logic            tick;
   logic [7:0]      lb;

   assign lb        = sc_map_byte(wdata, mode.msb_first, mode.invert);
   assign guard_len = mode.last_char ? G_TWO : GL_W'(guard_ext) + G_TWO;

   sc_etu_timer #(.W(ETU_W), .HALF(1'b0)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (st == TX_IDLE),
      .len     (etu_len),
      .tick    (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= TX_IDLE;
         bit_idx  <= '0;
         g_idx    <= '0;
         frame    <= '1;
         err_seen <= 1'b0;
      end else begin
         unique case (st)
            TX_IDLE: if (wr) begin
               frame   <= {^lb, lb, 1'b0};
               bit_idx <= '0;
               st      <= TX_SEND;
            end
            TX_SEND: if (tick) begin
               if (bit_idx == 4'd9) begin
                  st       <= TX_GUARD;
                  g_idx    <= '0;
                  err_seen <= 1'b0;
               end else begin
                  bit_idx <= bit_idx + 4'd1;
               end
            end
            TX_GUARD: if (tick) begin
               // one etu after parity end lies inside the error window
               if (g_idx == '0 && !mode.t1 && !line_s) err_seen <= 1'b1;
               if (g_idx == guard_len - G_ONE) begin
                  if (err_seen && !mode.t1) begin
                     st      <= TX_SEND;
                     bit_idx <= '0;
                  end else begin
                     st <= TX_IDLE;
                  end
               end else begin
                  g_idx <= g_idx + G_ONE;
               end
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   assign busy = (st != TX_IDLE);
   assign oe   = (st == TX_SEND) && !frame[bit_idx];

   // start bit is on the line as soon as busy rises
   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> oe);

   // a write during a transfer never reloads the frame
   p_frame_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(frame));
endmodule

// File: rtl/sc_rx.sv
module sc_rx
   import sc_pkg::*;
#(
   parameter int ETU_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msb_first,
   input  logic             invert,
   input  logic             t1,
   input  logic [ETU_W-1:0] etu_len,
   input  logic             enable,
   input  logic             line_s,
   output logic [7:0]       data,
   output logic             valid,
   output logic             perr,
   output logic             oe
);
   typedef enum logic [2:0] {RX_IDLE, RX_START, RX_BITS, RX_WAIT, RX_ERR} rx_st_e;

   rx_st_e     st;
   logic       prev;
   logic [7:0] sreg;
   logic [3:0] idx;
   logic       err_q;
   logic       tick;
   logic [8:0] nv;

   assign nv = {line_s, sreg};

   sc_etu_timer #(.W(ETU_W), .HALF(1'b1)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (st == RX_IDLE),
      .len     (etu_len),
      .tick    (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= RX_IDLE;
         prev  <= 1'b1;
         sreg  <= '0;
         idx   <= '0;
         err_q <= 1'b0;
         data  <= '0;
         valid <= 1'b0;
         perr  <= 1'b0;
      end else begin
         prev  <= line_s;
         valid <= 1'b0;
         perr  <= 1'b0;
         if (!enable) begin
            st <= RX_IDLE;
         end else begin
            unique case (st)
               RX_IDLE: if (prev && !line_s) st <= RX_START;
               RX_START: if (tick) begin
                  st  <= line_s ? RX_IDLE : RX_BITS;
                  idx <= '0;
               end
               RX_BITS: if (tick) begin
                  sreg <= nv[8:1];
                  if (idx == 4'd8) begin
                     err_q <= ^nv;
                     perr  <= ^nv;
                     valid <= !(^nv && !t1);
                     data  <= sc_map_byte(nv[7:0], msb_first, invert);
                     st    <= RX_WAIT;
                  end else begin
                     idx <= idx + 4'd1;
                  end
               end
               RX_WAIT: if (tick) st <= (err_q && !t1) ? RX_ERR : RX_IDLE;
               RX_ERR:  if (tick) st <= RX_IDLE;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   assign oe = (st == RX_ERR);

   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   p_no_drive_t1_r9: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> !t1);

   p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(oe) && enable) |=> oe);
endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr
   import sc_pkg::*;
#(
   parameter int ETU_W       = 16,
   parameter int GUARD_W     = 8,
   parameter int ETU_RESET   = 372,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic               cfg_msb_first,
   input  logic               cfg_invert,
   input  logic               cfg_t1,
   input  logic               cfg_last_char,
   input  logic [ETU_W-1:0]   cfg_etu,
   input  logic [GUARD_W-1:0] cfg_guard,
   input  logic               tx_wr,
   input  logic [7:0]         tx_data,
   output logic               tx_busy,
   output logic [7:0]         rx_data,
   output logic               rx_valid,
   output logic               rx_perr,
   input  logic               io_in,
   output logic               io_oe
);
   if (ETU_W < 3 || ETU_W > 30) begin : g_bad_etu_w
      $error("sc_xcvr: ETU_W out of range");
   end
   if (ETU_RESET < 4 || ETU_RESET >= (1 << ETU_W)) begin : g_bad_etu_rst
      $error("sc_xcvr: ETU_RESET must fit ETU_W and be at least 4");
   end
   if (GUARD_W < 1) begin : g_bad_guard_w
      $error("sc_xcvr: GUARD_W must be at least 1");
   end

   localparam logic [ETU_W-1:0] ETU_DEF = ETU_W'(ETU_RESET);

   sc_mode_t           mode_q;
   logic [ETU_W-1:0]   etu_q;
   logic [GUARD_W-1:0] guard_q;
   logic               line_s;
   logic               tx_oe;
   logic               rx_oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         etu_q   <= ETU_DEF;
         guard_q <= '0;
      end else if (cfg_load) begin
         mode_q  <= '{msb_first: cfg_msb_first, invert: cfg_invert,
                      t1: cfg_t1, last_char: cfg_last_char};
         etu_q   <= cfg_etu;
         guard_q <= cfg_guard;
      end
   end

   sc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (io_in),
      .q     (line_s)
   );

   sc_tx #(.ETU_W(ETU_W), .GUARD_W(GUARD_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q),
      .etu_len   (etu_q),
      .guard_ext (guard_q),
      .wr        (tx_wr),
      .wdata     (tx_data),
      .line_s    (line_s),
      .busy      (tx_busy),
      .oe        (tx_oe)
   );

   sc_rx #(.ETU_W(ETU_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .msb_first (mode_q.msb_first),
      .invert    (mode_q.invert),
      .t1        (mode_q.t1),
      .etu_len   (etu_q),
      .enable    (!tx_busy),
      .line_s    (line_s),
      .data      (rx_data),
      .valid     (rx_valid),
      .perr      (rx_perr),
      .oe        (rx_oe)
   );

   assign io_oe = tx_oe | rx_oe;

   p_half_duplex_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> !rx_oe);

   p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> ($stable(etu_q) && $stable(mode_q) && $stable(guard_q)));
endmodule

// File: tb/tb_sc_xcvr.sv
module tb_sc_xcvr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_load = 1'b0, cfg_msb_first = 1'b0, cfg_invert = 1'b0;
   logic       cfg_t1 = 1'b0, cfg_last_char = 1'b0;
   logic [15:0] cfg_etu = 16'd0;
   logic [7:0] cfg_guard = 8'd0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = 8'd0;
   logic       tx_busy, rx_valid, rx_perr, io_oe;
   logic [7:0] rx_data;
   logic       card_low = 1'b0;
   wire        line;

   assign line = ~(io_oe | card_low);

   always #4 clk = ~clk;

   sc_xcvr dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
      .cfg_t1(cfg_t1), .cfg_last_char(cfg_last_char),
      .cfg_etu(cfg_etu), .cfg_guard(cfg_guard),
      .tx_wr(tx_wr), .tx_data(tx_data), .tx_busy(tx_busy),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
      .io_in(line), .io_oe(io_oe)
   );

   int total = 0, bad = 0, rx_events = 0;
   bit done = 1'b0;
   bit m_msb = 0, m_inv = 0, m_t1 = 0, m_last = 0;
   int m_e = 372, m_g = 0;

   typedef struct {
      bit       v;
      bit       pe;
      bit [7:0] d;
      string    req;
   } rx_exp_t;
   rx_exp_t exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // bit i of the result is the i-th bit on the line (0 = start)
   function automatic bit [9:0] line_frame(input bit [7:0] d, input bit msb,
                                          input bit inv, input bit bad_par);
      bit [7:0] lb;
      for (int j = 0; j < 8; j++) lb[j] = inv ^ (msb ? d[7-j] : d[j]);
      return {(^lb) ^ bad_par, lb, 1'b0};
   endfunction

   task automatic load_cfg(input bit msb, input bit inv, input bit t1,
                           input bit last, input int etu, input int g);
      @(negedge clk);
      cfg_msb_first = msb; cfg_invert = inv; cfg_t1 = t1; cfg_last_char = last;
      cfg_etu = 16'(etu); cfg_guard = 8'(g); cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      m_msb = msb; m_inv = inv; m_t1 = t1; m_last = last; m_e = etu; m_g = g;
   endtask

   // driver and line monitor for one transmitted character
   task automatic do_tx(input bit [7:0] d, input bit card_err, input string req,
                        input int frames, input bit wr_again);
      int       f, c, fn, rel, ev0;
      bit [9:0] expf;
      bit [9:0] got [2];
      f    = (10 + (m_last ? 2 : 2 + m_g)) * m_e;
      expf = line_frame(d, m_msb, m_inv, 1'b0);
      got[0] = '1; got[1] = '1;
      ev0  = rx_events;
      @(negedge clk);
      tx_data = d; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
      c = 0;
      while (tx_busy && c < 4 * f) begin
         fn  = c / f;
         rel = c % f;
         if (fn < 2 && rel < 10 * m_e && rel % m_e == m_e / 2)
            got[fn][rel / m_e] = line;
         card_low = card_err && fn == 0 && rel >= 10 * m_e + m_e / 2
                    && rel < 11 * m_e + m_e / 2;
         if (wr_again && c == 3 * m_e) begin
            tx_data = ~d; tx_wr = 1'b1;
         end else begin
            tx_wr = 1'b0;
         end
         @(negedge clk);
         c++;
      end
      card_low = 1'b0;
      tx_wr    = 1'b0;
      chk(c == frames * f, req, "tx busy cycles", c, frames * f);
      chk(got[0] == expf, req, "tx line frame", int'(got[0]), int'(expf));
      if (frames == 2)
         chk(got[1] == expf, req, "tx repeated frame", int'(got[1]), int'(expf));
      chk(rx_events == ev0, "R12", "rx results during tx", rx_events - ev0, 0);
      repeat (2) @(negedge clk);
   endtask

   // card driver for one received character; pushes the expected result
   task automatic do_rx(input bit [7:0] d, input bit bad_par, input string req);
      bit [9:0] fr;
      rx_exp_t  e;
      fr   = line_frame(d, m_msb, m_inv, bad_par);
      e.v  = !(bad_par && !m_t1);
      e.pe = bad_par;
      e.d  = d;
      e.req = req;
      exp_q.push_back(e);
      @(negedge clk);
      for (int i = 0; i < 10; i++) begin
         card_low = !fr[i];
         repeat (m_e) @(negedge clk);
      end
      card_low = 1'b0;
      if (bad_par) begin
         repeat (m_e / 4) @(negedge clk);
         chk(line == 1'b1, req, "line just after parity", int'(line), 1);
         repeat (m_e - m_e / 4) @(negedge clk);
         chk(line == !e.v ? 1'b0 : 1'b1, req, "line in error window",
             int'(line), e.v ? 1 : 0);
         repeat (m_e) @(negedge clk);
         chk(line == 1'b1, req, "line after error window", int'(line), 1);
      end else begin
         repeat (2 * m_e) @(negedge clk);
      end
      repeat (m_e) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (rx_valid || rx_perr)) begin
         rx_events++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected rx result", int'(rx_data), 0);
         end else begin
            rx_exp_t e;
            e = exp_q.pop_front();
            chk(rx_valid == e.v, e.req, "rx_valid", int'(rx_valid), int'(e.v));
            chk(rx_perr == e.pe, e.req, "rx_perr", int'(rx_perr), int'(e.pe));
            if (e.v) chk(rx_data == e.d, e.req, "rx_data", int'(rx_data), int'(e.d));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int ev;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(io_oe == 1'b0, "R1", "io_oe after reset", int'(io_oe), 0);
      chk(tx_busy == 1'b0, "R1", "tx_busy after reset", int'(tx_busy), 0);
      chk(rx_valid == 1'b0, "R1", "rx_valid after reset", int'(rx_valid), 0);
      chk(line == 1'b1, "R1", "line after reset", int'(line), 1);
      // R1 default etu 372, T=0, LSB first, guard 2
      do_tx(8'hA5, 1'b0, "R1", 1, 1'b0);

      load_cfg(0, 0, 0, 0, 16, 1);
      do_tx(8'h3C, 1'b0, "R2", 1, 1'b0);
      do_tx(8'h01, 1'b0, "R3", 1, 1'b0);
      load_cfg(1, 0, 0, 0, 16, 1);
      do_tx(8'h1E, 1'b0, "R3", 1, 1'b0);
      load_cfg(0, 1, 0, 0, 16, 1);
      do_tx(8'h0F, 1'b0, "R4", 1, 1'b0);
      load_cfg(1, 1, 0, 0, 16, 1);
      do_tx(8'hC5, 1'b0, "R4", 1, 1'b0);
      // R5 guard length with and without last-character mode
      load_cfg(0, 0, 0, 1, 16, 3);
      do_tx(8'h77, 1'b0, "R5", 1, 1'b0);
      load_cfg(0, 0, 0, 0, 16, 3);
      do_tx(8'h77, 1'b0, "R5", 1, 1'b0);
      // R6 write while busy
      load_cfg(0, 0, 0, 0, 16, 1);
      do_tx(8'h55, 1'b0, "R6", 1, 1'b1);
      // R10 retransmit in T=0, none in T=1
      do_tx(8'h96, 1'b1, "R10", 2, 1'b0);
      load_cfg(0, 0, 1, 0, 16, 1);
      do_tx(8'h96, 1'b1, "R10", 1, 1'b0);

      // receive direction
      load_cfg(0, 0, 0, 0, 16, 1);
      do_rx(8'h5A, 1'b0, "R3");
      load_cfg(1, 0, 0, 0, 16, 1);
      do_rx(8'h5A, 1'b0, "R3");
      load_cfg(0, 1, 0, 0, 16, 1);
      do_rx(8'h0E, 1'b0, "R4");
      load_cfg(1, 1, 0, 0, 16, 1);
      do_rx(8'hB1, 1'b0, "R4");
      load_cfg(0, 0, 0, 0, 16, 1);
      do_rx(8'h3C, 1'b1, "R8");
      do_rx(8'h3C, 1'b0, "R8");
      load_cfg(0, 0, 1, 0, 16, 1);
      do_rx(8'h66, 1'b1, "R9");

      // R7 false start: low for a quarter etu only
      ev = rx_events;
      @(negedge clk);
      card_low = 1'b1;
      repeat (m_e / 4) @(negedge clk);
      card_low = 1'b0;
      repeat (12 * m_e) @(negedge clk);
      chk(rx_events == ev, "R7", "result after glitch", rx_events - ev, 0);
      do_rx(8'hC3, 1'b0, "R7");

      // R11 inputs change without cfg_load: no effect
      @(negedge clk);
      cfg_etu = 16'd8; cfg_last_char = 1'b1; cfg_msb_first = 1'b1;
      cfg_invert = 1'b1; cfg_guard = 8'd5;
      do_tx(8'h42, 1'b0, "R11", 1, 1'b0);
      do_rx(8'h24, 1'b0, "R11");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R8", "missing rx results", exp_q.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule